// File: doc/BRIEF.md
# DMA Channel Sequencer

This block keeps the control state of a small multi-channel DMA engine and chooses the channel that moves data next. Software loads each channel's control word through a single write port. The word holds an enable, an auto re-enable, a chain enable, a chain direction, a flag to accept events while the channel is disabled, and a priority. Hardware start events mark a channel as having pending work. Abort events cancel that work and switch the channel off. Block-complete pulses from the data mover either switch the finished channel off or leave it running. They can also switch on a neighbour channel that is chained to it.

A single grant is given at a time to the enabled channel with pending work and the highest priority. The grant stays with that channel until the data mover signals that the transaction is done. A channel that loses its enable while it holds the grant stays busy until that transaction finishes. This gives software a graceful suspend that it can observe.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, every control bit, every pending event, every grant, every busy bit and every event-detected bit is 0.
- R2: A write with `cfg_we` high loads the control word of channel `cfg_ch` at the next clock edge. The fields are bit 0 enable, bit 1 auto re-enable, bit 2 chain enable, bit 3 chain direction, bit 4 accept-events-while-disabled, and bits 6:5 priority.
- R3: A start event on a channel is registered when the channel is enabled or accepts events while disabled. A registered start sets that channel's event-detected bit at the next edge. Any other start event is discarded.
- R4: When no grant is held, the next edge grants the channel that is enabled, has a pending event and has the largest priority field (3 highest). Ties go to the lowest channel index. No candidate means no grant.
- R5: At most one grant bit is high. A grant is held until `xfer_done` is sampled high, and it is cleared at that edge. Issuing a grant clears that channel's event-detected bit.
- R6: On a block-complete pulse, a channel with auto re-enable 0 loses its enable. A channel with auto re-enable 1 keeps it.
- R7: With chain enable 1, a channel is switched on by the block-complete of channel i-1 when its direction bit is 0, and by channel i+1 when its direction bit is 1. Channel 0 with direction 0 and the last channel with direction 1 have no neighbour and are never chained.
- R8: With chain enable 0, neighbour block-complete pulses do not change the enable, whatever the direction bit holds.
- R9: An abort event that would be registered under the R3 rule clears both the enable and the pending event of its channel. An abort that would not be registered is ignored.
- R10: Busy is high while a channel is enabled or holds the grant. Clearing the enable during a grant keeps busy high until `xfer_done` ends that grant.
- R11: When a start and an abort reach the same channel in one cycle, the abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_wdata | input | 7 | Control word, field layout in R2 |
| start_ev | input | 4 | Start event pulse per channel |
| abort_ev | input | 4 | Abort event pulse per channel |
| blk_done | input | 4 | Block-complete pulse per channel |
| xfer_done | input | 1 | Data mover finished the granted transaction |
| gnt_o | output | 4 | One-hot grant |
| en_o | output | 4 | Channel enable bits |
| busy_o | output | 4 | Channel busy bits |
| evdet_o | output | 4 | Event-detected bits |

## Verification
Several properties are checked on every cycle: the grant is one-hot, it is held and then released on `xfer_done`, and every new grant lands on a channel that was enabled with work pending. Discarded starts, registered aborts, retained enables under auto re-enable, and busy during a grant are also checked each cycle. Only the bench scenarios can show that the priority order and tie-break pick the right winner among several candidates. The same holds for the chain direction reaching the correct neighbour and ignoring the missing neighbour at each end. It also holds for an ignored abort leaving a latched event intact, and for the suspend sequence that busy makes visible.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int NCH = 4,
  parameter int PW  = 2,
  localparam int CW = $clog2(NCH),
  localparam int DW = 5 + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] start_ev,
  input  logic [NCH-1:0] abort_ev,
  input  logic [NCH-1:0] blk_done,
  input  logic           xfer_done,
  output logic [NCH-1:0] gnt_o,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] busy_o,
  output logic [NCH-1:0] evdet_o
);

  logic [NCH-1:0] en_q, aen_q, chn_q, chns_q, aed_q, pend_q, gnt_q;
  logic [PW-1:0]  pri_q [NCH];
  logic [NCH-1:0] wr, ev_ok, chain_hit, lo_nb, hi_nb;
  logic [NCH-1:0] cand, pick, nxt_gnt;

  assign cand    = en_q & pend_q;
  assign nxt_gnt = (gnt_q == '0) ? pick : '0;
  assign gnt_o   = gnt_q;
  assign en_o    = en_q;
  assign busy_o  = en_q | gnt_q;
  assign evdet_o = pend_q;

  always_comb begin
    logic          found;
    logic [PW-1:0] best;
    pick  = '0;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cand[i] && (!found || pri_q[i] > best)) begin
        pick  = '0;
        pick[i] = 1'b1;
        best  = pri_q[i];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 gnt_q <= '0;
    else if (gnt_q != '0) begin
      if (xfer_done)            gnt_q <= '0;
    end else                    gnt_q <= pick;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_lo0
      assign lo_nb[i] = 1'b0;
    end else begin : g_lo
      assign lo_nb[i] = blk_done[i-1];
    end
    if (i == NCH - 1) begin : g_hiN
      assign hi_nb[i] = 1'b0;
    end else begin : g_hi
      assign hi_nb[i] = blk_done[i+1];
    end

    assign wr[i]        = cfg_we && (cfg_ch == CW'(i));
    assign ev_ok[i]     = en_q[i] | aed_q[i];
    assign chain_hit[i] = chn_q[i] & (chns_q[i] ? hi_nb[i] : lo_nb[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i] <= 1'b0; aen_q[i] <= 1'b0; chn_q[i] <= 1'b0;
        chns_q[i] <= 1'b0; aed_q[i] <= 1'b0; pri_q[i] <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (wr[i]) begin
          en_q[i]   <= cfg_wdata[0];
          aen_q[i]  <= cfg_wdata[1];
          chn_q[i]  <= cfg_wdata[2];
          chns_q[i] <= cfg_wdata[3];
          aed_q[i]  <= cfg_wdata[4];
          pri_q[i]  <= cfg_wdata[5 +: PW];
        end
        if (blk_done[i] && !aen_q[i]) en_q[i] <= 1'b0;
        if (chain_hit[i])             en_q[i] <= 1'b1;
        if (abort_ev[i] && ev_ok[i])  en_q[i] <= 1'b0;

        if (abort_ev[i] && ev_ok[i])      pend_q[i] <= 1'b0;
        else if (start_ev[i] && ev_ok[i]) pend_q[i] <= 1'b1;
        else if (nxt_gnt[i])              pend_q[i] <= 1'b0;
      end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_ev[i] && ev_ok[i] |=> !en_q[i] && !pend_q[i]); // R9
    AST_START_DISCARDED: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev[i] && !en_q[i] && !aed_q[i] && !pend_q[i] |=> !pend_q[i]); // R3
    AST_AUTO_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done[i] && aen_q[i] && en_q[i] && !abort_ev[i] && !wr[i] |=> en_q[i]); // R6
    AST_BUSY_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_q[i] && !xfer_done |=> busy_o[i]); // R10
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q)); // R5
  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q != '0 && !xfer_done |=> gnt_q == $past(gnt_q)); // R5
  AST_GNT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q != '0 && xfer_done |=> gnt_q == '0); // R5
  AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q == '0 |=> gnt_q == '0 || (gnt_q & $past(en_q & pend_q)) != '0); // R4

endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [6:0] cfg_wdata = '0;
  logic [3:0] start_ev = '0, abort_ev = '0, blk_done = '0;
  logic       xfer_done = 1'b0;
  logic [3:0] gnt_o, en_o, busy_o, evdet_o;
  int tests = 0, fails = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .start_ev(start_ev), .abort_ev(abort_ev), .blk_done(blk_done), .xfer_done(xfer_done),
    .gnt_o(gnt_o), .en_o(en_o), .busy_o(busy_o), .evdet_o(evdet_o)
  );

  // {pri3,pri2,pri1,pri0}, pending mask, expected grant
  localparam logic [15:0] VEC [8] = '{
    {8'b00_00_00_00, 4'b1111, 4'b0001},
    {8'b00_00_00_00, 4'b1100, 4'b0100},
    {8'b11_00_00_00, 4'b1111, 4'b1000},
    {8'b01_10_10_01, 4'b1111, 4'b0010},
    {8'b01_00_00_01, 4'b1110, 4'b1000},
    {8'b00_11_01_00, 4'b0011, 4'b0010},
    {8'b11_11_11_11, 4'b1010, 4'b0010},
    {8'b10_00_00_11, 4'b1001, 4'b0001}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", r, act, exp);
    end
  endtask

  task automatic wcfg(input int ch, input logic [6:0] d);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pstart(input logic [3:0] m); start_ev = m; tick(); start_ev = '0; endtask
  task automatic pabort(input logic [3:0] m); abort_ev = m; tick(); abort_ev = '0; endtask
  task automatic pblk(input logic [3:0] m);   blk_done = m; tick(); blk_done = '0; endtask
  task automatic pdone();                     xfer_done = 1'b1; tick(); xfer_done = 1'b0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 grant", 8'(gnt_o), 8'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 enable", 8'(en_o), 8'h0);
    chk("R1 busy", 8'(busy_o), 8'h0);
    chk("R1 evdet", 8'(evdet_o), 8'h0);

    wcfg(3, 7'b0000001);
    chk("R2 enable bit loaded", 8'(en_o), 8'b1000);
    wcfg(3, 7'b0000000);
    chk("R2 enable bit cleared", 8'(en_o), 8'h0);

    for (int v = 0; v < 8; v++) begin
      for (int c = 0; c < 4; c++) wcfg(c, {VEC[v][8 + 2*c +: 2], 5'b00001});
      pstart(VEC[v][7:4]);
      tick();
      chk($sformatf("R4 arbitration vector %0d", v), 8'(gnt_o), 8'(VEC[v][3:0]));
      chk($sformatf("R5 evdet after grant vector %0d", v), 8'(evdet_o),
          8'(VEC[v][7:4] & ~VEC[v][3:0]));
      xfer_done = 1'b1; abort_ev = 4'hf;
      tick();
      xfer_done = 1'b0; abort_ev = '0;
    end
    tick();
    chk("R5 idle after cleanup", 8'(gnt_o), 8'h0);

    // start events while disabled
    wcfg(1, 7'b0000000);
    pstart(4'b0010);
    chk("R3 start discarded", 8'(evdet_o), 8'h0);
    wcfg(1, 7'b0010000);
    pstart(4'b0010);
    chk("R3 start latched while disabled", 8'(evdet_o), 8'b0010);
    tick();
    chk("R4 disabled channel not granted", 8'(gnt_o), 8'h0);
    wcfg(1, 7'b0010001);
    tick();
    chk("R5 grant issued", 8'(gnt_o), 8'b0010);
    chk("R5 evdet cleared by grant", 8'(evdet_o), 8'h0);
    tick(); tick(); tick();
    chk("R5 grant held", 8'(gnt_o), 8'b0010);
    wcfg(1, 7'b0010000);
    chk("R10 enable cleared", 8'(en_o), 8'h0);
    chk("R10 busy during suspend", 8'(busy_o), 8'b0010);
    pdone();
    chk("R5 grant released", 8'(gnt_o), 8'h0);
    chk("R10 busy dropped", 8'(busy_o), 8'h0);

    // auto re-enable
    wcfg(2, 7'b0000011);
    pblk(4'b0100);
    chk("R6 auto keeps enable", 8'(en_o), 8'b0100);
    wcfg(2, 7'b0000001);
    pblk(4'b0100);
    chk("R6 enable cleared on complete", 8'(en_o), 8'h0);

    // chaining
    wcfg(1, 7'b0000100);
    pblk(4'b0001);
    chk("R7 dir0 chained from ch0", 8'(en_o), 8'b0010);
    wcfg(1, 7'b0001100);
    pblk(4'b0001);
    chk("R7 dir1 ignores ch0", 8'(en_o), 8'h0);
    pblk(4'b0100);
    chk("R7 dir1 chained from ch2", 8'(en_o), 8'b0010);
    wcfg(1, 7'b0001000);
    pblk(4'b0100);
    chk("R8 chain off dir1", 8'(en_o), 8'h0);
    pblk(4'b0001);
    chk("R8 chain off lower neighbour", 8'(en_o), 8'h0);
    wcfg(0, 7'b0000100);
    pblk(4'b1000);
    chk("R7 ch0 dir0 no neighbour", 8'(en_o), 8'h0);
    wcfg(3, 7'b0001100);
    pblk(4'b0001);
    chk("R7 last channel dir1 no neighbour", 8'(en_o), 8'h0);
    wcfg(0, 7'b0001100);
    pblk(4'b0010);
    chk("R7 ch0 dir1 chained from ch1", 8'(en_o), 8'b0001);
    wcfg(0, 7'b0000000);
    wcfg(3, 7'b0000000);

    // aborts
    wcfg(2, 7'b0000001);
    pabort(4'b0100);
    chk("R9 abort clears enable", 8'(en_o), 8'h0);
    wcfg(3, 7'b0010000);
    pstart(4'b1000);
    chk("R3 start latched ch3", 8'(evdet_o), 8'b1000);
    wcfg(3, 7'b0000000);
    pabort(4'b1000);
    chk("R9 abort ignored when disabled", 8'(evdet_o), 8'b1000);
    wcfg(3, 7'b0010000);
    pabort(4'b1000);
    chk("R9 abort clears pending", 8'(evdet_o), 8'h0);

    wcfg(2, 7'b0000001);
    start_ev = 4'b0100; abort_ev = 4'b0100;
    tick();
    start_ev = '0; abort_ev = '0;
    chk("R11 abort wins evdet", 8'(evdet_o), 8'h0);
    chk("R11 abort wins enable", 8'(en_o), 8'h0);
    tick();
    chk("R11 no grant after collision", 8'(gnt_o), 8'h0);

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule